// File: doc/BRIEF.md
# Instruction Fetch Patch Remap Unit

This block sits beside the instruction and literal fetch path of a processor core. It holds a small bank of word-aligned address comparators. When a fetch to the low code region hits an armed comparator, the block fetches a replacement word from a patch table in RAM and hands that word back in place of the word the memory returned. A patch can therefore replace any aligned 32-bit word of read-only code without touching the code itself.

Software programs a control register, a table base register and one register per comparator through a simple write port with a combinational read-back. The table holds one 32-bit entry per comparator, so a hit on comparator `k` reads the entry at the table base plus `4*k`. The table base always lies in the 0x2000_0000 to 0x3FFF_FFFF window and is aligned to the size of the table. Fetch results come out one cycle after the request, which is also the latency of both the memory and the table read port.

There are two resets. The power-on reset clears the configuration. The system reset stands for the watchdog, pin and other warm resets: it flushes the fetch pipeline but leaves every configuration register as it was, so a patch set up before a warm reset is already in force for the first fetches after it.

Top module: `fetch_patch_unit`

## Requirements
- R1: While `por_n` is low and after its release, the control register reads 0x0000_0040, the base register reads 0x2000_0000, every comparator register reads 0, and every fetch returns `mem_rdata` with `fetch_patched` low.
- R2: The register word offset is `reg_addr[4:2]`. Offset 0 is control, offset 1 (byte 0x04) is the base, and offset 2+k (byte 0x08+4k) is comparator k. Offsets 6 and 7 read 0 and ignore writes.
- R3: A write to control takes effect only when bit 1 (key) of the data is 1, in which case bit 0 becomes the unit enable; a write with bit 1 clear leaves the enable unchanged. Control reads back the enable in bit 0, the comparator count in bits 7:4 and 0 elsewhere.
- R4: A fetch hits comparator k when the unit is enabled, the comparator's bit 0 (enable) is 1, its bits 31:30 are 00, `fetch_addr[31:29]` is 000 and `fetch_addr[28:2]` equals the comparator's bits 28:2; `fetch_addr[1:0]` do not matter.
- R5: A comparator whose bits 31:30 are not 00 never causes a substitution.
- R6: Base writes keep bits 28:4; the base reads back as 0x2000_0000 plus those bits. On a hit by comparator k, `tbl_req` is high in the request cycle and `tbl_addr` equals 0x2000_0000 + (base bits 28:4) + 4*k.
- R7: One cycle after each fetch request `fetch_valid` is high; `fetch_data` equals `tbl_rdata` and `fetch_patched` is high if that request hit, otherwise `fetch_data` equals `mem_rdata` and `fetch_patched` is low. Without a request, `fetch_valid` is low in the next cycle.
- R8: When several comparators hit the same fetch, the lowest-numbered one selects the table entry.
- R9: `sys_rst_n` low clears `fetch_valid` and the pending result but keeps enable, base and comparators; only `por_n` clears them.
- R10: A fetch with `fetch_addr[31:29]` not 000 is never patched, even when its bits 28:2 equal an armed comparator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears configuration and pipeline |
| sys_rst_n | input | 1 | Warm system reset, active low, asynchronous; clears only the pipeline |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (5) | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| fetch_req | input | 1 | Fetch request this cycle |
| fetch_addr | input | 32 | Fetch byte address |
| mem_rdata | input | 32 | Original memory word, valid the cycle after the request |
| tbl_req | output | 1 | Patch table read request, same cycle as the fetch |
| tbl_addr | output | 32 | Patch table entry byte address |
| tbl_rdata | input | 32 | Patch table word, valid the cycle after `tbl_req` |
| fetch_valid | output | 1 | Fetch result valid |
| fetch_data | output | 32 | Fetch result word |
| fetch_patched | output | 1 | Fetch result came from the patch table |

## Verification
The assertions take for granted that `mem_rdata` and `tbl_rdata` answer with exactly one cycle of latency, and that the resets move only at quiet points of the clock; the bench drives every input, resets included, on the falling edge and gives both read ports a fresh word every cycle, so the one-cycle pairing is always met. They also assume that a fetch result is consumed in the cycle it appears, because the unit has no stall input; the bench therefore compares every output on every cycle against its own model rather than waiting for a handshake. Register accesses are only issued to word-aligned byte addresses, so the ignored low address bits never carry meaning in the stimulus.

// File: rtl/fpatch_pkg.sv
package fpatch_pkg;

   // Architectural layout of a 32-bit fetch address.
   localparam int unsigned   ADDR_BITS    = 32;
   localparam int unsigned   REGION_LSB   = 29;
   localparam int unsigned   WORD_MSB     = 28;
   localparam int unsigned   WORD_LSB     = 2;
   localparam int unsigned   WORD_BITS    = WORD_MSB - WORD_LSB + 1;

   // Region codes in address bits 31:29.
   localparam logic [2:0]    CODE_REGION  = 3'b000;
   localparam logic [2:0]    TABLE_REGION = 3'b001;

   // Comparator function code: only remapping is modelled.
   localparam logic [1:0]    FUNC_REMAP   = 2'b00;

   // Control register bit positions.
   localparam int unsigned   CTRL_EN_BIT  = 0;
   localparam int unsigned   CTRL_KEY_BIT = 1;
   localparam int unsigned   CTRL_CNT_LSB = 4;

   // Fixed register word offsets; comparators follow CMP_BASE_WORD.
   localparam int unsigned   CTRL_WORD     = 0;
   localparam int unsigned   BASE_WORD     = 1;
   localparam int unsigned   CMP_BASE_WORD = 2;

   // Stored image of one comparator register.
   typedef struct packed {
      logic [1:0]           func;
      logic [WORD_BITS-1:0] word;
      logic                 en;
   } cmp_cfg_t;

   function automatic cmp_cfg_t word_to_cmp(input logic [ADDR_BITS-1:0] w);
      cmp_cfg_t c;
      c.func = w[31:30];
      c.word = w[WORD_MSB:WORD_LSB];
      c.en   = w[0];
      return c;
   endfunction

   function automatic logic [ADDR_BITS-1:0] cmp_to_word(input cmp_cfg_t c);
      return {c.func, 1'b0, c.word, 1'b0, c.en};
   endfunction

endpackage

// File: rtl/fpatch_regs.sv
module fpatch_regs
   import fpatch_pkg::*;
#(
   parameter int unsigned NUM_CMP = 4,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned IDX_W   = 2,
   parameter int unsigned BASE_W  = 25
) (
   input  logic                     clk,
   input  logic                     por_n,
   input  logic                     reg_wr,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [31:0]              reg_wdata,
   output logic [31:0]              reg_rdata,
   output logic                     unit_en,
   output logic [BASE_W-1:0]        base_hi,
   output cmp_cfg_t [NUM_CMP-1:0]   cmp_cfg
);

   localparam int unsigned WIDX_W  = ADDR_W - 2;
   localparam int unsigned BASE_LO = IDX_W + 2;
   localparam logic [3:0]  CMP_CNT = 4'(NUM_CMP);

   logic [WIDX_W-1:0] widx;
   logic              wr_ctrl;
   logic              wr_base;
   logic              en_q;
   logic [BASE_W-1:0] base_q;

   assign widx    = reg_addr[ADDR_W-1:2];
   assign wr_ctrl = reg_wr && (widx == WIDX_W'(CTRL_WORD));
   assign wr_base = reg_wr && (widx == WIDX_W'(BASE_WORD));

   // Control: enable changes only when the key bit accompanies the write.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         en_q <= 1'b0;
      end else if (wr_ctrl && reg_wdata[CTRL_KEY_BIT]) begin
         en_q <= reg_wdata[CTRL_EN_BIT];
      end
   end

   // Table base: only the bits above the table size are stored.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         base_q <= '0;
      end else if (wr_base) begin
         base_q <= reg_wdata[WORD_MSB:BASE_LO];
      end
   end

   // One storage slot per comparator.
   for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
      localparam int unsigned SLOT_WORD = CMP_BASE_WORD + i;
      logic     wr_slot;
      cmp_cfg_t slot_q;

      assign wr_slot = reg_wr && (widx == WIDX_W'(SLOT_WORD));

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            slot_q <= '0;
         end else if (wr_slot) begin
            slot_q <= word_to_cmp(reg_wdata);
         end
      end

      assign cmp_cfg[i] = slot_q;
   end

   assign unit_en = en_q;
   assign base_hi = base_q;

   // Read-back multiplexer; unmapped words read as zero.
   always_comb begin
      reg_rdata = '0;
      if (widx == WIDX_W'(CTRL_WORD)) begin
         reg_rdata = '0;
         reg_rdata[CTRL_EN_BIT] = en_q;
         reg_rdata[CTRL_CNT_LSB +: 4] = CMP_CNT;
      end else if (widx == WIDX_W'(BASE_WORD)) begin
         reg_rdata = {TABLE_REGION, base_q, {BASE_LO{1'b0}}};
      end
      for (int i = 0; i < int'(NUM_CMP); i++) begin
         if (widx == WIDX_W'(CMP_BASE_WORD + i)) begin
            reg_rdata = cmp_to_word(cmp_cfg[i]);
         end
      end
   end

   AST_KEYLESS_CTRL_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
      (wr_ctrl && !reg_wdata[CTRL_KEY_BIT]) |=> $stable(en_q)); // R3

   AST_CFG_HELD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!por_n)
      !reg_wr |=> ($stable(en_q) && $stable(base_q) && $stable(cmp_cfg))); // R9

endmodule

// File: rtl/fpatch_match.sv
module fpatch_match
   import fpatch_pkg::*;
#(
   parameter int unsigned NUM_CMP = 4,
   parameter int unsigned IDX_W   = 2
) (
   input  logic                   unit_en,
   input  cmp_cfg_t [NUM_CMP-1:0] cmp_cfg,
   input  logic [31:0]            fetch_addr,
   output logic                   hit,
   output logic [IDX_W-1:0]       hit_idx
);

   logic [NUM_CMP-1:0] match_vec;
   logic               in_code;

   assign in_code = unit_en && (fetch_addr[31:REGION_LSB] == CODE_REGION);

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      assign match_vec[i] = in_code
                         && cmp_cfg[i].en
                         && (cmp_cfg[i].func == FUNC_REMAP)
                         && (cmp_cfg[i].word == fetch_addr[WORD_MSB:WORD_LSB]);
   end

   assign hit = |match_vec;

   if (NUM_CMP == 1) begin : g_single
      assign hit_idx = '0;
   end else begin : g_prio
      // Scan downwards so the lowest matching index is the last one kept.
      always_comb begin
         hit_idx = '0;
         for (int i = int'(NUM_CMP) - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
               hit_idx = IDX_W'(i);
            end
         end
      end
   end

endmodule

// File: rtl/fpatch_subst.sv
module fpatch_subst
   import fpatch_pkg::*;
#(
   parameter int unsigned IDX_W  = 2,
   parameter int unsigned BASE_W = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic              hit,
   input  logic [IDX_W-1:0]  hit_idx,
   input  logic [BASE_W-1:0] base_hi,
   input  logic [31:0]       mem_rdata,
   input  logic [31:0]       tbl_rdata,
   output logic              tbl_req,
   output logic [31:0]       tbl_addr,
   output logic              fetch_valid,
   output logic [31:0]       fetch_data,
   output logic              fetch_patched
);

   logic valid_q;
   logic patched_q;

   // Table entry address: region code, base bits, comparator index, byte lane.
   assign tbl_req  = fetch_req && hit;
   assign tbl_addr = {TABLE_REGION, base_hi, hit_idx, 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q   <= 1'b0;
         patched_q <= 1'b0;
      end else begin
         valid_q   <= fetch_req;
         patched_q <= tbl_req;
      end
   end

   assign fetch_valid   = valid_q;
   assign fetch_patched = patched_q;
   assign fetch_data    = patched_q ? tbl_rdata : mem_rdata;

   AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |=> fetch_valid); // R7

   AST_IDLE_GIVES_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_req |=> !fetch_valid); // R7

endmodule

// File: rtl/fetch_patch_unit.sv
module fetch_patch_unit
   import fpatch_pkg::*;
#(
   parameter int unsigned NUM_CMP = 4,
   parameter int unsigned ADDR_W  = 5
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              fetch_req,
   input  logic [31:0]       fetch_addr,
   input  logic [31:0]       mem_rdata,
   output logic              tbl_req,
   output logic [31:0]       tbl_addr,
   input  logic [31:0]       tbl_rdata,
   output logic              fetch_valid,
   output logic [31:0]       fetch_data,
   output logic              fetch_patched
);

   localparam int unsigned IDX_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;
   localparam int unsigned BASE_W = WORD_MSB - (IDX_W + 2) + 1;

   initial begin
      if (NUM_CMP < 1 || NUM_CMP > 15)
         $fatal(1, "NUM_CMP must lie in 1..15");
      if (ADDR_W < 3 || ADDR_W > 16)
         $fatal(1, "ADDR_W must lie in 3..16");
      if ((1 << (ADDR_W - 2)) < (NUM_CMP + CMP_BASE_WORD))
         $fatal(1, "ADDR_W too narrow for the register map");
      if (BASE_W + IDX_W + 5 != ADDR_BITS)
         $fatal(1, "table address fields do not fill 32 bits");
   end

   logic                   rst_any_n;
   logic                   unit_en;
   logic [BASE_W-1:0]      base_hi;
   cmp_cfg_t [NUM_CMP-1:0] cmp_cfg;
   logic                   hit;
   logic [IDX_W-1:0]       hit_idx;

   // The pipeline clears on either reset; configuration only on power-on.
   assign rst_any_n = por_n && sys_rst_n;

   fpatch_regs #(
      .NUM_CMP (NUM_CMP),
      .ADDR_W  (ADDR_W),
      .IDX_W   (IDX_W),
      .BASE_W  (BASE_W)
   ) u_regs (
      .clk       (clk),
      .por_n     (por_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .unit_en   (unit_en),
      .base_hi   (base_hi),
      .cmp_cfg   (cmp_cfg)
   );

   fpatch_match #(
      .NUM_CMP (NUM_CMP),
      .IDX_W   (IDX_W)
   ) u_match (
      .unit_en    (unit_en),
      .cmp_cfg    (cmp_cfg),
      .fetch_addr (fetch_addr),
      .hit        (hit),
      .hit_idx    (hit_idx)
   );

   fpatch_subst #(
      .IDX_W  (IDX_W),
      .BASE_W (BASE_W)
   ) u_subst (
      .clk           (clk),
      .rst_n         (rst_any_n),
      .fetch_req     (fetch_req),
      .hit           (hit),
      .hit_idx       (hit_idx),
      .base_hi       (base_hi),
      .mem_rdata     (mem_rdata),
      .tbl_rdata     (tbl_rdata),
      .tbl_req       (tbl_req),
      .tbl_addr      (tbl_addr),
      .fetch_valid   (fetch_valid),
      .fetch_data    (fetch_data),
      .fetch_patched (fetch_patched)
   );

   AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_any_n)
      tbl_req |-> unit_en); // R4

   AST_HIT_CODE_REGION_ONLY: assert property (@(posedge clk) disable iff (!rst_any_n)
      tbl_req |-> (fetch_addr[31:REGION_LSB] == CODE_REGION)); // R10

   AST_PATCH_FROM_TABLE_READ: assert property (@(posedge clk) disable iff (!rst_any_n)
      fetch_patched |-> $past(tbl_req)); // R7

endmodule

// File: tb/fetch_patch_unit_test.sv
module fetch_patch_unit_test;

   localparam int NC = 4;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          por_n, sys_rst_n;
   logic          reg_wr;
   logic [AW-1:0] reg_addr;
   logic [31:0]   reg_wdata, reg_rdata;
   logic          fetch_req;
   logic [31:0]   fetch_addr, mem_rdata, tbl_rdata, tbl_addr, fetch_data;
   logic          tbl_req, fetch_valid, fetch_patched;

   always #5 clk = ~clk;

   fetch_patch_unit #(.NUM_CMP(NC), .ADDR_W(AW)) uut (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .mem_rdata(mem_rdata),
      .tbl_req(tbl_req), .tbl_addr(tbl_addr), .tbl_rdata(tbl_rdata),
      .fetch_valid(fetch_valid), .fetch_data(fetch_data), .fetch_patched(fetch_patched)
   );

   int vectors = 0;
   int misses  = 0;

   // Behavioural reference state.
   bit          m_en;
   logic [31:0] m_base;
   logic [31:0] m_cmp [NC];
   bit          p_valid, p_hit;

   function automatic int model_hit(input logic [31:0] a);
      if (!m_en || a >= 32'h2000_0000) return -1;
      for (int i = 0; i < NC; i++) begin
         if (m_cmp[i][0] && m_cmp[i][31:30] == 2'b00 &&
             (m_cmp[i] & 32'h1FFF_FFFC) == (a & 32'h1FFF_FFFC))
            return i;
      end
      return -1;
   endfunction

   function automatic logic [31:0] model_read(input logic [AW-1:0] ra);
      int w;
      w = int'(ra) / 4;
      if (w == 0) return (m_en ? 32'd1 : 32'd0) | (NC << 4);
      if (w == 1) return 32'h2000_0000 | (m_base & 32'h1FFF_FFF0);
      if (w >= 2 && w < 2 + NC) return m_cmp[w-2] & 32'hDFFF_FFFD;
      return 32'h0;
   endfunction

   task automatic report(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
   endtask

   task automatic step(input string tag);
      int          h;
      logic [31:0] exp_addr;
      mem_rdata = 32'hC0DE_0000 + vectors;
      tbl_rdata = 32'h7AB1_0000 + vectors * 3;
      if (!por_n) begin
         m_en = 0; m_base = '0;
         for (int i = 0; i < NC; i++) m_cmp[i] = '0;
      end
      if (!por_n || !sys_rst_n) begin p_valid = 0; p_hit = 0; end
      #1;
      vectors++;
      h = fetch_req ? model_hit(fetch_addr) : -1;
      if (reg_rdata !== model_read(reg_addr)) report(tag, "reg_rdata", reg_rdata, model_read(reg_addr));
      if (tbl_req !== (h >= 0)) report(tag, "tbl_req", 32'(tbl_req), 32'(h >= 0));
      if (h >= 0) begin
         exp_addr = 32'h2000_0000 + (m_base & 32'h1FFF_FFF0) + 32'(4 * h);
         if (tbl_addr !== exp_addr) report(tag, "tbl_addr", tbl_addr, exp_addr);
      end
      if (fetch_valid !== p_valid) report(tag, "fetch_valid", 32'(fetch_valid), 32'(p_valid));
      if (p_valid) begin
         if (fetch_patched !== p_hit) report(tag, "fetch_patched", 32'(fetch_patched), 32'(p_hit));
         if (fetch_data !== (p_hit ? tbl_rdata : mem_rdata))
            report(tag, "fetch_data", fetch_data, p_hit ? tbl_rdata : mem_rdata);
      end
      @(posedge clk);
      if (por_n && reg_wr) begin
         case (int'(reg_addr) / 4)
            0: if (reg_wdata[1]) m_en = reg_wdata[0];
            1: m_base = reg_wdata;
            default: if (int'(reg_addr) / 4 < 2 + NC) m_cmp[int'(reg_addr) / 4 - 2] = reg_wdata;
         endcase
      end
      if (por_n && sys_rst_n) begin
         p_valid = fetch_req;
         p_hit   = (h >= 0);
      end
      @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
      reg_wr = 1; reg_addr = a; reg_wdata = d; fetch_req = 0;
      step(tag);
      reg_wr = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input string tag);
      reg_addr = a; fetch_req = 0;
      step(tag);
   endtask

   task automatic fetch(input logic [31:0] a, input string tag);
      fetch_req = 1; fetch_addr = a;
      step(tag);
      fetch_req = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      misses++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      por_n = 0; sys_rst_n = 1; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
      fetch_req = 0; fetch_addr = '0; mem_rdata = '0; tbl_rdata = '0;
      @(negedge clk);
      // R1: state during and after power-on reset
      fetch(32'h0800_5418, "R1");
      rd(5'h00, "R1");
      por_n = 1;
      rd(5'h00, "R1"); rd(5'h04, "R1"); rd(5'h08, "R1"); rd(5'h14, "R1");
      fetch(32'h0800_5418, "R1");
      fetch(32'h0000_0000, "R1");
      // R2: unmapped offsets
      rd(5'h18, "R2");
      wr(5'h1C, 32'hFFFF_FFFF, "R2");
      rd(5'h1C, "R2"); rd(5'h10, "R2"); rd(5'h00, "R2");
      // R6: base write and read-back
      wr(5'h04, 32'hFFFF_1234, "R6");
      rd(5'h04, "R6");
      wr(5'h08, 32'h0800_5419, "R4");
      wr(5'h0C, 32'h0800_0EF1, "R4");
      rd(5'h08, "R2"); rd(5'h0C, "R2");
      // R3: key-less write is ignored
      wr(5'h00, 32'h0000_0001, "R3");
      rd(5'h00, "R3");
      fetch(32'h0800_5418, "R3");
      wr(5'h00, 32'h0000_0003, "R3");
      rd(5'h00, "R3");
      // R4/R6/R7: hits, byte lanes and misses
      fetch(32'h0800_5418, "R4");
      fetch(32'h0800_541A, "R4");
      fetch(32'h0800_0EF0, "R6");
      fetch(32'h0800_5414, "R7");
      rd(5'h00, "R7");
      for (int k = 0; k < 6; k++) begin
         fetch_req = 1;
         fetch_addr = (k % 2 == 0) ? 32'h0800_0EF3 : 32'h0800_0EF4;
         step("R7");
      end
      fetch_req = 0;
      step("R7");
      // R8: priority among duplicates
      wr(5'h10, 32'h0800_5419, "R8");
      wr(5'h14, 32'h0800_5419, "R8");
      fetch(32'h0800_5418, "R8");
      wr(5'h08, 32'h0800_5418, "R8");
      fetch(32'h0800_5418, "R8");
      // R5: non-remap function
      wr(5'h14, 32'h8000_0101, "R5");
      rd(5'h14, "R5");
      fetch(32'h0000_0100, "R5");
      wr(5'h14, 32'h4000_0101, "R5");
      fetch(32'h0000_0100, "R5");
      // R10: upper regions alias bits 28:2 but never hit
      fetch(32'h2800_5418, "R10");
      fetch(32'hE800_0EF0, "R10");
      // R9: warm reset flushes pipeline, keeps configuration
      fetch_req = 1; fetch_addr = 32'h0800_0EF0;
      sys_rst_n = 0;
      step("R9");
      fetch_req = 0;
      step("R9");
      sys_rst_n = 1;
      rd(5'h00, "R9"); rd(5'h04, "R9"); rd(5'h0C, "R9");
      fetch(32'h0800_0EF0, "R9");
      fetch(32'h0800_5418, "R9");
      // R3: keyed disable
      wr(5'h00, 32'h0000_0002, "R3");
      fetch(32'h0800_0EF0, "R3");
      wr(5'h00, 32'h0000_0003, "R3");
      // R9/R1: power-on reset clears everything
      fetch_req = 1; fetch_addr = 32'h0800_0EF0;
      step("R9");
      por_n = 0;
      step("R9");
      fetch_req = 0;
      por_n = 1;
      rd(5'h00, "R1"); rd(5'h04, "R1"); rd(5'h0C, "R1");
      fetch(32'h0800_0EF0, "R1");
      step("R1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule